// File: doc/BRIEF.md
# Dual-Rail Three-Valued Fault Effect Classifier

This block runs two copies of a small sequential netlist side by side, one fault-free and one with a selectable stuck-at fault. Both copies compute in a three-valued system: each signal is carried on two wires, so a value can be 0, 1 or unknown. Every state bit starts a run as unknown, and the unknown value spreads only where the logic allows it.

The netlist is a ring of `W` cells. Cell `i` takes a single-rail data bit and a single-rail hold bit from the primary inputs, and the state of cell `i-1` (cyclically). The next state is `NOR(AND(data[i], state[i-1]), hold[i])`. The primary inputs can never be unknown, so they stay single-rail until they meet the dual-rail logic. There they are widened.

A classifier compares the two copies' outputs on every evaluation step. It keeps two sticky flags per run:
- a hard flag, set when the two copies show opposite known values;
- a potential flag, set when the fault-free copy is known while the faulty copy is unknown.

A run starts with a start pulse, advances one step per step pulse, and is read out through the flags.

Top module: `tvl_fault_grader`

## Requirements
- R1: Output `i` of each copy sits at bits `[2i+1:2i]` as a pair {upper rail, lower rail}. The codes are 00 for 0, 11 for 1 and 01 for unknown. Code 10 never appears.
- R2: Reset, and every cycle with `runStart` high, set every state bit of both copies to unknown (01) at the next clock edge.
- R3: Each step applies `s[i] <= NOR(AND(dataIn[i], s[(i-1) mod W]), holdIn[i])` in three-valued logic, with the single-rail inputs widened as 0→00 and 1→11. AND gives 0 if either side is 0, 1 if both are 1, and unknown otherwise. NOR gives 0 if either side is 1, 1 if both are 0, and unknown otherwise. Outside step cycles the outputs hold.
- R4: While `faultOn` is high, the faulty copy forces site `faultSite` to the known value `faultStuck`. The site numbering is:
  - sites 0..W-1: data input of cell `i`;
  - sites W..2W-1: AND output of cell `i`;
  - sites 2W..3W-1: NOR output of cell `i`.
  The fault-free copy is never affected.
- R5: A step in which some output is known in both copies with different values sets `hardDet` at that step's edge.
- R6: A step in which some output is known in the fault-free copy and unknown in the faulty copy sets the potential status at that step's edge.
- R7: `potDet` is low whenever `hardDet` is high.
- R8: Both flags are sticky. They are cleared only by reset or `runStart`, and a cleared flag reads 0 the cycle after the start pulse.
- R9: Step pulses after reset and before the first `runStart` have no effect. A `runStart` in the same cycle as `stepEn` wins, and no step is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| runStart | input | 1 | Begin a run: state to unknown, flags cleared |
| stepEn | input | 1 | Evaluate and clock one step of both copies |
| dataIn | input | W | Single-rail data inputs of the ring cells |
| holdIn | input | W | Single-rail hold inputs of the ring cells |
| faultOn | input | 1 | Enable the fault in the faulty copy |
| faultSite | input | SITE_W | Fault site index (see R4) |
| faultStuck | input | 1 | Stuck value of the injected fault |
| goodOut | output | 2*W | Dual-rail outputs of the fault-free copy |
| faultyOut | output | 2*W | Dual-rail outputs of the faulty copy |
| hardDet | output | 1 | Sticky hard-detected flag |
| potDet | output | 1 | Sticky potentially-detected flag, masked by hardDet |

## Verification
The bench builds the block with `W = 4`, which gives twelve fault sites and a four-cell ring. In that ring an unknown value circulates without end while every data bit is 1 and every hold bit is 0. This makes three outcomes reachable:
- a run in which the faulty copy never becomes known, giving a potential detection;
- a run in which one cell's stuck value clashes with a late-settling fault-free value, giving a hard detection;
- a run whose difference only shows after a given number of steps.
Switching the fault within a run lets potential detection come first and hard detection follow, which is how priority and stickiness are checked.

// File: rtl/tvl_pkg.sv
package tvl_pkg;

  // Dual-rail code {upper, lower}: 00 = 0, 11 = 1, 01 = unknown
  typedef logic [1:0] dr_t;

  localparam dr_t DR_ZERO = 2'b00;
  localparam dr_t DR_ONE  = 2'b11;
  localparam dr_t DR_UNK  = 2'b01;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic initState;
    logic advance;
    logic observe;
  } strobes_t;

  function automatic dr_t drFromBit(input logic b);
    return {b, b};
  endfunction

  // Non-inverting cells: the gate is replicated on each rail
  function automatic dr_t drAnd(input dr_t a, input dr_t b);
    return a & b;
  endfunction

  function automatic dr_t drOr(input dr_t a, input dr_t b);
    return a | b;
  endfunction

  // Inverting cell: invert each rail and swap them
  function automatic dr_t drInv(input dr_t a);
    return {~a[0], ~a[1]};
  endfunction

  function automatic dr_t drNor(input dr_t a, input dr_t b);
    return drInv(drOr(a, b));
  endfunction

  function automatic logic drKnown(input dr_t a);
    return a[1] == a[0];
  endfunction

endpackage

// File: rtl/tvl_control.sv
module tvl_control
  import tvl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     runStart,
  input  logic     stepEn,
  output strobes_t strobes
);

  logic runActive;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      runActive <= 1'b0;
    end else if (runStart) begin
      runActive <= 1'b1;
    end
  end

  always_comb begin
    strobes.initState = runStart;
    strobes.advance   = stepEn & runActive & ~runStart;
    strobes.observe   = stepEn & runActive & ~runStart;
  end

endmodule

// File: rtl/tvl_ring.sv
module tvl_ring
  import tvl_pkg::*;
#(
  parameter int W      = 4,
  parameter int SITE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strobes,
  input  logic [W-1:0]      dataIn,
  input  logic [W-1:0]      holdIn,
  input  logic              faultOn,
  input  logic [SITE_W-1:0] faultSite,
  input  logic              faultStuck,
  output logic [2*W-1:0]    stateOut
);

  localparam int SITES = 3 * W;
  localparam logic [2*W-1:0] ALL_UNK = {W{DR_UNK}};

  logic [2*W-1:0] stQ;
  logic [2*W-1:0] stD;

  // Override one net with a known stuck value when it is the selected site
  function automatic dr_t forceSite(input dr_t v, input int idx, input logic en,
                                    input logic [SITE_W-1:0] site, input logic stuck);
    if (en && idx < SITES && int'(site) == idx) begin
      return drFromBit(stuck);
    end
    return v;
  endfunction

  always_comb begin
    stD = '0;
    for (int i = 0; i < W; i++) begin
      dr_t dV;
      dr_t pV;
      dr_t nV;
      dV = forceSite(drFromBit(dataIn[i]), i, faultOn, faultSite, faultStuck);
      pV = forceSite(drAnd(dV, stQ[2*((i+W-1)%W) +: 2]), W + i, faultOn, faultSite, faultStuck);
      nV = forceSite(drNor(pV, drFromBit(holdIn[i])), 2*W + i, faultOn, faultSite, faultStuck);
      stD[2*i +: 2] = nV;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stQ <= ALL_UNK;
    end else if (strobes.initState) begin
      stQ <= ALL_UNK;
    end else if (strobes.advance) begin
      stQ <= stD;
    end
  end

  assign stateOut = stQ;

endmodule

// File: rtl/tvl_classify.sv
module tvl_classify
  import tvl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  strobes_t       strobes,
  input  logic [2*W-1:0] goodVec,
  input  logic [2*W-1:0] faultyVec,
  output logic           hardDet,
  output logic           potDet
);

  logic [W-1:0] hardHit;
  logic [W-1:0] potHit;
  logic         hardQ;
  logic         potQ;

  for (genvar i = 0; i < W; i++) begin : g_cmp
    dr_t g;
    dr_t f;
    assign g = goodVec[2*i +: 2];
    assign f = faultyVec[2*i +: 2];
    assign hardHit[i] = drKnown(g) & drKnown(f) & (g[0] != f[0]);
    assign potHit[i]  = drKnown(g) & ~drKnown(f);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hardQ <= 1'b0;
      potQ  <= 1'b0;
    end else if (strobes.initState) begin
      hardQ <= 1'b0;
      potQ  <= 1'b0;
    end else if (strobes.observe) begin
      hardQ <= hardQ | (|hardHit);
      potQ  <= potQ | (|potHit);
    end
  end

  assign hardDet = hardQ;
  assign potDet  = potQ & ~hardQ;

endmodule

// File: rtl/tvl_datapath.sv
module tvl_datapath
  import tvl_pkg::*;
#(
  parameter int W      = 4,
  parameter int SITE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strobes,
  input  logic [W-1:0]      dataIn,
  input  logic [W-1:0]      holdIn,
  input  logic              faultOn,
  input  logic [SITE_W-1:0] faultSite,
  input  logic              faultStuck,
  output logic [2*W-1:0]    goodOut,
  output logic [2*W-1:0]    faultyOut,
  output logic              hardDet,
  output logic              potDet
);

  tvl_ring #(.W(W), .SITE_W(SITE_W)) i_good (
    .clk(clk), .rst(rst), .strobes(strobes),
    .dataIn(dataIn), .holdIn(holdIn),
    .faultOn(1'b0), .faultSite(faultSite), .faultStuck(faultStuck),
    .stateOut(goodOut)
  );

  tvl_ring #(.W(W), .SITE_W(SITE_W)) i_faulty (
    .clk(clk), .rst(rst), .strobes(strobes),
    .dataIn(dataIn), .holdIn(holdIn),
    .faultOn(faultOn), .faultSite(faultSite), .faultStuck(faultStuck),
    .stateOut(faultyOut)
  );

  tvl_classify #(.W(W)) i_classify (
    .clk(clk), .rst(rst), .strobes(strobes),
    .goodVec(goodOut), .faultyVec(faultyOut),
    .hardDet(hardDet), .potDet(potDet)
  );

endmodule

// File: rtl/tvl_fault_grader.sv
module tvl_fault_grader
  import tvl_pkg::*;
#(
  parameter int W = 4,
  localparam int SITE_W = $clog2(3 * W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              runStart,
  input  logic              stepEn,
  input  logic [W-1:0]      dataIn,
  input  logic [W-1:0]      holdIn,
  input  logic              faultOn,
  input  logic [SITE_W-1:0] faultSite,
  input  logic              faultStuck,
  output logic [2*W-1:0]    goodOut,
  output logic [2*W-1:0]    faultyOut,
  output logic              hardDet,
  output logic              potDet
);

  strobes_t strobes;

  tvl_control i_control (
    .clk(clk), .rst(rst), .runStart(runStart), .stepEn(stepEn), .strobes(strobes)
  );

  tvl_datapath #(.W(W), .SITE_W(SITE_W)) i_datapath (
    .clk(clk), .rst(rst), .strobes(strobes),
    .dataIn(dataIn), .holdIn(holdIn),
    .faultOn(faultOn), .faultSite(faultSite), .faultStuck(faultStuck),
    .goodOut(goodOut), .faultyOut(faultyOut),
    .hardDet(hardDet), .potDet(potDet)
  );

endmodule

// File: rtl/tvl_fault_grader_chk.sv
module tvl_fault_grader_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           runStart,
  input logic           stepEn,
  input logic [2*W-1:0] goodOut,
  input logic [2*W-1:0] faultyOut,
  input logic           hardDet,
  input logic           potDet
);

  localparam logic [2*W-1:0] ALL_UNK = {W{2'b01}};

  function automatic logic anyIllegal(input logic [2*W-1:0] v);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (v[2*i+1] && !v[2*i]) bad = 1'b1;
    end
    return bad;
  endfunction

  p_no_illegal_r1: assert property (@(posedge clk) disable iff (rst)
    !anyIllegal(goodOut) && !anyIllegal(faultyOut));

  p_start_unknown_r2: assert property (@(posedge clk) disable iff (rst)
    runStart |=> (goodOut == ALL_UNK) && (faultyOut == ALL_UNK));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!stepEn && !runStart) |=> $stable(goodOut) && $stable(faultyOut));

  p_priority_r7: assert property (@(posedge clk) disable iff (rst)
    hardDet |-> !potDet);

  p_hard_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (hardDet && !runStart) |=> hardDet);

  p_pot_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (potDet && !runStart) |=> (potDet || hardDet));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    runStart |=> !hardDet && !potDet);

endmodule

bind tvl_fault_grader tvl_fault_grader_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .runStart(runStart), .stepEn(stepEn),
  .goodOut(goodOut), .faultyOut(faultyOut), .hardDet(hardDet), .potDet(potDet)
);

// File: tb/test_tvl_fault_grader.sv
module test_tvl_fault_grader;

  localparam int W = 4;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic runStart = 1'b0;
  logic stepEn = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] holdIn = '0;
  logic faultOn = 1'b0;
  logic [SW-1:0] faultSite = '0;
  logic faultStuck = 1'b0;
  logic [2*W-1:0] goodOut;
  logic [2*W-1:0] faultyOut;
  logic hardDet;
  logic potDet;

  int total = 0;
  int bad = 0;

  // model state: 0, 1, 2 = unknown
  int gS[W];
  int fS[W];

  always #5 clk = ~clk;

  tvl_fault_grader #(.W(W)) i_tvl_fault_grader (
    .clk(clk), .rst(rst), .runStart(runStart), .stepEn(stepEn),
    .dataIn(dataIn), .holdIn(holdIn),
    .faultOn(faultOn), .faultSite(faultSite), .faultStuck(faultStuck),
    .goodOut(goodOut), .faultyOut(faultyOut), .hardDet(hardDet), .potDet(potDet)
  );

  typedef struct packed {
    logic       on;
    logic [3:0] site;
    logic       stuck;
    logic [3:0] d;
    logic [3:0] k;
    logic [3:0] steps;
    logic       expHard;
    logic       expPot;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TABLE [NV] = '{
    '{1'b0, 4'd0,  1'b0, 4'b1110, 4'b0000, 4'd6, 1'b0, 1'b0},
    '{1'b1, 4'd8,  1'b1, 4'b0000, 4'b1111, 4'd2, 1'b1, 1'b0},
    '{1'b1, 4'd8,  1'b1, 4'b0000, 4'b1111, 4'd1, 1'b0, 1'b0},
    '{1'b1, 4'd0,  1'b1, 4'b1110, 4'b0000, 4'd6, 1'b0, 1'b1},
    '{1'b1, 4'd11, 1'b1, 4'b1110, 4'b0000, 4'd5, 1'b1, 1'b0},
    '{1'b1, 4'd11, 1'b1, 4'b1110, 4'b0000, 4'd4, 1'b0, 1'b0},
    '{1'b1, 4'd5,  1'b0, 4'b1110, 4'b0000, 4'd3, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int tAnd(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    if (a == 1 && b == 1) return 1;
    return 2;
  endfunction

  function automatic int tNor(input int a, input int b);
    if (a == 1 || b == 1) return 0;
    if (a == 0 && b == 0) return 1;
    return 2;
  endfunction

  function automatic logic [1:0] enc(input int v);
    if (v == 0) return 2'b00;
    if (v == 1) return 2'b11;
    return 2'b01;
  endfunction

  function automatic int inj(input int v, input int idx, input bit isFaulty);
    if (isFaulty && faultOn && int'(faultSite) == idx) return faultStuck ? 1 : 0;
    return v;
  endfunction

  task automatic modelUnknown();
    for (int i = 0; i < W; i++) begin
      gS[i] = 2;
      fS[i] = 2;
    end
  endtask

  task automatic modelAdvance();
    int gN[W];
    int fN[W];
    for (int i = 0; i < W; i++) begin
      int prev = (i + W - 1) % W;
      int dv;
      int pv;
      dv = inj(int'(dataIn[i]), i, 1'b0);
      pv = inj(tAnd(dv, gS[prev]), W + i, 1'b0);
      gN[i] = inj(tNor(pv, int'(holdIn[i])), 2*W + i, 1'b0);
      dv = inj(int'(dataIn[i]), i, 1'b1);
      pv = inj(tAnd(dv, fS[prev]), W + i, 1'b1);
      fN[i] = inj(tNor(pv, int'(holdIn[i])), 2*W + i, 1'b1);
    end
    for (int i = 0; i < W; i++) begin
      gS[i] = gN[i];
      fS[i] = fN[i];
    end
  endtask

  task automatic checkOuts(input string req);
    logic [2*W-1:0] eg;
    logic [2*W-1:0] ef;
    for (int i = 0; i < W; i++) begin
      eg[2*i +: 2] = enc(gS[i]);
      ef[2*i +: 2] = enc(fS[i]);
    end
    check(goodOut == eg, req, "good outputs", 32'(goodOut), 32'(eg));
    check(faultyOut == ef, req, "faulty outputs", 32'(faultyOut), 32'(ef));
  endtask

  // all tasks start and end at a falling edge
  task automatic stepOnce(input string req);
    stepEn = 1'b1;
    @(negedge clk);
    stepEn = 1'b0;
    modelAdvance();
    checkOuts(req);
  endtask

  task automatic startRun();
    runStart = 1'b1;
    @(negedge clk);
    runStart = 1'b0;
    modelUnknown();
    checkOuts("R2");
    check(!hardDet && !potDet, "R8", "flags after start", {hardDet, potDet}, 0);
  endtask

  task automatic finishUp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishUp();
  end

  initial begin
    modelUnknown();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    checkOuts("R2");
    check(!hardDet && !potDet, "R8", "flags after reset", {hardDet, potDet}, 0);

    // R9: steps before any run are ignored
    dataIn = 4'b1110;
    holdIn = 4'b1111;
    repeat (3) begin
      stepEn = 1'b1;
      @(negedge clk);
      stepEn = 1'b0;
      checkOuts("R9");
    end

    // R9: start wins over a step in the same cycle
    runStart = 1'b1;
    stepEn = 1'b1;
    @(negedge clk);
    runStart = 1'b0;
    stepEn = 1'b0;
    checkOuts("R9");

    // table of runs: R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      faultOn = TABLE[v].on;
      faultSite = TABLE[v].site;
      faultStuck = TABLE[v].stuck;
      dataIn = TABLE[v].d;
      holdIn = TABLE[v].k;
      startRun();
      for (int s = 0; s < int'(TABLE[v].steps); s++) stepOnce("R3/R4");
      // hold cycle with no step: outputs keep their values (R3)
      @(negedge clk);
      checkOuts("R3");
      check(hardDet == TABLE[v].expHard, "R5", "hard flag", 32'(hardDet), 32'(TABLE[v].expHard));
      check(potDet == TABLE[v].expPot, "R6", "potential flag", 32'(potDet), 32'(TABLE[v].expPot));
    end

    // priority and stickiness: potential first, hard after a fault switch
    faultOn = 1'b1;
    faultSite = 4'd0;
    faultStuck = 1'b1;
    dataIn = 4'b1110;
    holdIn = 4'b0000;
    startRun();
    repeat (3) stepOnce("R4");
    check(potDet && !hardDet, "R6", "potential before switch", {hardDet, potDet}, 1);
    faultSite = 4'd8;
    holdIn = 4'b1111;
    repeat (2) stepOnce("R4");
    check(hardDet, "R5", "hard after switch", 32'(hardDet), 1);
    check(!potDet, "R7", "potential masked by hard", 32'(potDet), 0);
    faultOn = 1'b0;
    repeat (2) stepOnce("R4");
    check(hardDet && !potDet, "R8", "hard sticky after fault off", {hardDet, potDet}, 2);
    startRun();

    finishUp();
  end

endmodule